// File: doc/BRIEF.md
# ADC Channel Activation Controller

This block sits between the trigger sources of a chip and the arbiter that feeds an analog-to-digital converter. For each of its conversion channels it decides when a conversion is wanted. The channel may be started by software, by a pulse from a timer, or by a match between a free-running counter and a compare value that belongs to the channel. While a channel wants a conversion, its request line toward the arbiter stays high.

When the converter reports a finished result for a channel, the block stores the 12-bit value in that channel's data register. It also raises the channel's completion flag. If a new result arrives before the previous one was taken, the channel flags an overrun and records whether the old value was kept or replaced.

A channel can be set to single or repeat mode. It can also be placed under a protection lock. While the lock holds, the channel issues no new requests until software has read the data and cleared the completion flag.

Each channel runs a four-state machine:
- **IDLE**: not busy.
- **REQ**: busy and requesting.
- **LOCK_IDLE**: locked after a single-mode result.
- **LOCK_RPT**: locked after a repeat-mode result, still busy.

Its transitions are:
- IDLE→REQ on an accepted activation that is not cancelled in the same cycle.
- REQ→IDLE on a busy-clear, or on a result in single mode without the lock.
- REQ→REQ on a result in repeat mode without the lock.
- REQ→LOCK_IDLE or REQ→LOCK_RPT on a result with the lock active, depending on the mode.
- LOCK_IDLE→IDLE and LOCK_RPT→REQ on release, which needs both a read and a cleared flag, or the lock turned off.
- LOCK_RPT→LOCK_IDLE on a busy-clear.

Top module: `adc_act_ctrl`

## Requirements

The register map, with write address in `reg_addr`:

| Address | Register | Fields |
|---|---|---|
| 0 | Per-channel configuration | bit0 interrupt enable; bits 2:1 source (0 software, 1 timer, 2 compare match); bit3 repeat; bit4 protection |
| 1 | Per-channel clear | bit0 busy-clear; bit1 flag-clear |
| 2 | Per-channel compare value | the compare value |
| 3 | Software select mask | one bit per channel |
| 4 | Software start | bit0 |

The read word is laid out as bit15 ERR, bit14 ERRST, bits 13:12 zero, bits 11:0 result.

- R1: After reset every request, busy and interrupt output is 0, and every channel reads back 0x0000.
- R2: Writing 1 to the start bit (address 4, bit0) activates exactly those channels that are selected in the mask and configured for source 0. The busy and request outputs of those channels rise after that write.
- R3: A pulse on a channel's timer trigger input activates that channel only when its source is 1. On a channel with another source it has no effect.
- R4: A channel with source 2 activates in a cycle where the free-running counter equals its compare value, and not while they differ.
- R5: A result for a busy channel clears busy and request in single mode. In repeat mode the channel stays busy and requesting.
- R6: A busy-clear write (address 1, bit0) takes a busy channel out of busy and request in the next cycle.
- R7: A conversion-done strobe sets the channel's completion flag in the next cycle, and the interrupt output equals that flag AND the interrupt enable. A flag-clear write (address 1, bit1) clears it.
- R8: A read of a channel returns its last stored result in bits 11:0, with ERR in bit15 and ERRST in bit14.
- R9: On a result that arrives while the flag is set and protection is not in force, the new data is stored with ERR=1 and ERRST=1. A read clears ERR and ERRST.
- R10: With protection on and a source other than 2, a result locks the channel. While locked:
  - no request is issued, and starts are ignored;
  - a further result sets ERR=1 and ERRST=0 and keeps the old data.

  The lock releases only after both a read and a flag-clear. After release a repeat-mode channel requests again.
- R11: Protection has no effect on a channel with source 2. That channel activates on a match even while its flag is set and unread.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_ch | input | CHW | Channel addressed by a per-channel write |
| reg_wdata | input | 32 | Write data |
| rd_en | input | 1 | Data register read strobe |
| rd_ch | input | CHW | Channel being read |
| rd_data | output | 16 | Read word of channel `rd_ch` |
| tmr_trig | input | NCH | Timer trigger pulses, one per channel |
| frc | input | CW | Free-running counter value |
| cv_done | input | 1 | Conversion finished strobe |
| cv_ch | input | CHW | Channel of the finished conversion |
| cv_data | input | DW | Conversion result |
| req_o | output | NCH | Conversion request per channel toward the arbiter |
| busy_o | output | NCH | Busy bit per channel |
| irq_o | output | NCH | Completion interrupt per channel |

## Verification

The bench targets the places where channels interact with each other and with their own flags.

- **Start write on non-software channels.** A start write reaches a selected channel whose source is not software. A decoder that ignored the source would wrongly activate it.
- **Counter one below the compare value.** A loose comparison would raise the request too early.
- **Result arriving while locked.** The old data must stay in place, with ERR=1 and ERRST=0. A design that let the lock overwrite the data would report the wrong result.
- **Release needing both a read and a flag-clear.** A design that released on either one alone would raise the request too soon.
- **Compare-match channel with the lock set.** Its flag is set and unread, yet it must activate again. A design that applied the lock to it would fail here.
- **Random stream on one channel.** A seeded random mix of results, reads and clears checks the overrun bits against a model.

// File: rtl/adc_act_pkg.sv
package adc_act_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REQ       = 2'd1,
        ST_LOCK_IDLE = 2'd2,
        ST_LOCK_RPT  = 2'd3
    } chan_state_t;

    localparam logic [1:0] SRC_SW  = 2'd0;
    localparam logic [1:0] SRC_TMR = 2'd1;
    localparam logic [1:0] SRC_CMP = 2'd2;

    localparam logic [2:0] A_CFG   = 3'd0;
    localparam logic [2:0] A_CLR   = 3'd1;
    localparam logic [2:0] A_CMP   = 3'd2;
    localparam logic [2:0] A_SEL   = 3'd3;
    localparam logic [2:0] A_START = 3'd4;

    localparam int CFG_W = 5;
    localparam int RD_W  = 16;

    typedef struct packed {
        logic       prt;
        logic       rpt;
        logic [1:0] src;
        logic       inte;
    } chan_cfg_t;

endpackage

// File: rtl/adc_act_trig.sv
module adc_act_trig
    import adc_act_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [1:0]    src,
    input  logic          sw_hit,
    input  logic          tmr_hit,
    input  logic [CW-1:0] frc,
    input  logic [CW-1:0] cmp,
    output logic          act
);

    always_comb begin
        unique case (src)
            SRC_SW:  act = sw_hit;
            SRC_TMR: act = tmr_hit;
            SRC_CMP: act = (frc == cmp);
            default: act = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_act_chan.sv
module adc_act_chan
    import adc_act_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cmp_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [CW-1:0]    cmp_wdata,
    input  logic             busyc,
    input  logic             intc,
    input  logic             sw_hit,
    input  logic             tmr_hit,
    input  logic [CW-1:0]    frc,
    input  logic             done,
    input  logic [DW-1:0]    done_data,
    input  logic             rd_hit,
    output logic             busy,
    output logic             req,
    output logic             int_flag,
    output logic             irq,
    output logic [RD_W-1:0]  rd_word
);

    localparam int PAD = RD_W - 2 - DW;

    chan_cfg_t   cfg_q;
    logic [CW-1:0] cmp_q;
    chan_state_t state_q, state_d;
    logic        int_q, err_q, errst_q, rd_seen_q;
    logic [DW-1:0] data_q;
    logic        act, prt_eff, release_ok;

    adc_act_trig #(.CW(CW)) u_trig (
        .src     (cfg_q.src),
        .sw_hit  (sw_hit),
        .tmr_hit (tmr_hit),
        .frc     (frc),
        .cmp     (cmp_q),
        .act     (act)
    );

    assign prt_eff    = cfg_q.prt && (cfg_q.src != SRC_CMP);
    assign release_ok = !prt_eff || (rd_seen_q && !int_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act && !busyc) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (busyc)
                    state_d = ST_IDLE;
                else if (done) begin
                    if (prt_eff) state_d = cfg_q.rpt ? ST_LOCK_RPT : ST_LOCK_IDLE;
                    else         state_d = cfg_q.rpt ? ST_REQ : ST_IDLE;
                end
            end
            ST_LOCK_IDLE: begin
                if (release_ok) state_d = ST_IDLE;
            end
            ST_LOCK_RPT: begin
                if (busyc)           state_d = ST_LOCK_IDLE;
                else if (release_ok) state_d = ST_REQ;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cmp_q     <= '0;
            int_q     <= 1'b0;
            err_q     <= 1'b0;
            errst_q   <= 1'b0;
            rd_seen_q <= 1'b0;
            data_q    <= '0;
        end else begin
            if (cfg_we) cfg_q <= chan_cfg_t'(cfg_wdata);
            if (cmp_we) cmp_q <= cmp_wdata;
            if (done) begin
                int_q     <= 1'b1;
                rd_seen_q <= 1'b0;
                if (int_q) begin
                    err_q <= 1'b1;
                    if (prt_eff) begin
                        errst_q <= 1'b0;
                    end else begin
                        errst_q <= 1'b1;
                        data_q  <= done_data;
                    end
                end else begin
                    data_q <= done_data;
                end
            end else begin
                if (intc) int_q <= 1'b0;
                if (rd_hit) begin
                    err_q     <= 1'b0;
                    errst_q   <= 1'b0;
                    rd_seen_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        busy     = (state_q == ST_REQ) || (state_q == ST_LOCK_RPT);
        req      = (state_q == ST_REQ);
        int_flag = int_q;
        irq      = int_q && cfg_q.inte;
        rd_word  = {err_q, errst_q, {PAD{1'b0}}, data_q};
    end

endmodule

// File: rtl/adc_act_ctrl.sv
module adc_act_ctrl
    import adc_act_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int DW  = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [CHW-1:0]  reg_ch,
    input  logic [31:0]     reg_wdata,
    input  logic            rd_en,
    input  logic [CHW-1:0]  rd_ch,
    output logic [RD_W-1:0] rd_data,
    input  logic [NCH-1:0]  tmr_trig,
    input  logic [CW-1:0]   frc,
    input  logic            cv_done,
    input  logic [CHW-1:0]  cv_ch,
    input  logic [DW-1:0]   cv_data,
    output logic [NCH-1:0]  req_o,
    output logic [NCH-1:0]  busy_o,
    output logic [NCH-1:0]  irq_o
);

    logic [NCH-1:0]  sel_q;
    logic            start;
    logic [NCH-1:0]  int_vec;
    logic [RD_W-1:0] rd_words [NCH];

    assign start = reg_we && (reg_addr == A_START) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             sel_q <= '0;
        else if (reg_we && reg_addr == A_SEL)   sel_q <= reg_wdata[NCH-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit_ch;
        assign hit_ch = reg_we && (reg_ch == CHW'(i));

        adc_act_chan #(.CW(CW), .DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (hit_ch && reg_addr == A_CFG),
            .cmp_we    (hit_ch && reg_addr == A_CMP),
            .cfg_wdata (reg_wdata[CFG_W-1:0]),
            .cmp_wdata (reg_wdata[CW-1:0]),
            .busyc     (hit_ch && reg_addr == A_CLR && reg_wdata[0]),
            .intc      (hit_ch && reg_addr == A_CLR && reg_wdata[1]),
            .sw_hit    (start && sel_q[i]),
            .tmr_hit   (tmr_trig[i]),
            .frc       (frc),
            .done      (cv_done && cv_ch == CHW'(i)),
            .done_data (cv_data),
            .rd_hit    (rd_en && rd_ch == CHW'(i)),
            .busy      (busy_o[i]),
            .req       (req_o[i]),
            .int_flag  (int_vec[i]),
            .irq       (irq_o[i]),
            .rd_word   (rd_words[i])
        );
    end

    assign rd_data = rd_words[rd_ch];

endmodule

// File: rtl/adc_act_chk.sv
module adc_act_chk #(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [2:0]     reg_addr,
    input logic [CHW-1:0] reg_ch,
    input logic           clr_busy_bit,
    input logic           cv_done,
    input logic [CHW-1:0] cv_ch,
    input logic [NCH-1:0] req_o,
    input logic [NCH-1:0] busy_o,
    input logic [NCH-1:0] irq_o,
    input logic [NCH-1:0] int_vec
);

    assert_req_implies_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o & ~busy_o) == '0);

    assert_done_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cv_done |=> int_vec[$past(cv_ch)]);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~int_vec) == '0);

    assert_busy_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd1 && clr_busy_bit && busy_o[reg_ch])
        |=> !busy_o[$past(reg_ch)]);

endmodule

bind adc_act_ctrl adc_act_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_ch       (reg_ch),
    .clr_busy_bit (reg_wdata[0]),
    .cv_done      (cv_done),
    .cv_ch        (cv_ch),
    .req_o        (req_o),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .int_vec      (int_vec)
);

// File: tb/adc_act_ctrl_bench.sv
module adc_act_ctrl_bench;

    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam int DW  = 12;
    localparam int CHW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [CHW-1:0]  reg_ch = '0;
    logic [31:0]     reg_wdata = '0;
    logic            rd_en = 1'b0;
    logic [CHW-1:0]  rd_ch = '0;
    logic [15:0]     rd_data;
    logic [NCH-1:0]  tmr_trig = '0;
    logic [CW-1:0]   frc = 16'hFFFF;
    logic            cv_done = 1'b0;
    logic [CHW-1:0]  cv_ch = '0;
    logic [DW-1:0]   cv_data = '0;
    logic [NCH-1:0]  req_o, busy_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_act_ctrl #(.NCH(NCH), .CW(CW), .DW(DW)) u_adc_act_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_ch(reg_ch), .reg_wdata(reg_wdata), .rd_en(rd_en), .rd_ch(rd_ch),
        .rd_data(rd_data), .tmr_trig(tmr_trig), .frc(frc), .cv_done(cv_done),
        .cv_ch(cv_ch), .cv_data(cv_data), .req_o(req_o), .busy_o(busy_o),
        .irq_o(irq_o)
    );

    function automatic logic [31:0] cfgw(input bit inte, input logic [1:0] src,
                                         input bit rpt, input bit prt);
        return {27'd0, prt, rpt, src, inte};
    endfunction

    function automatic logic [15:0] word(input bit err, input bit errst,
                                         input logic [11:0] d);
        return {err, errst, 2'b00, d};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int ch, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_ch = CHW'(ch); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic conv(input int ch, input logic [11:0] d);
        @(negedge clk);
        cv_done = 1'b1; cv_ch = CHW'(ch); cv_data = d;
        @(negedge clk);
        cv_done = 1'b0;
    endtask

    task automatic rd(input int ch, output logic [15:0] w);
        @(negedge clk);
        rd_en = 1'b1; rd_ch = CHW'(ch);
        #1 w = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] w;
        bit m_int, m_err, m_errst;
        logic [11:0] m_data;
        void'($urandom(32'h5EED_0A0C));

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 req", req_o, 0);
        chk("R1 irq", irq_o, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, w);
            chk("R1 read", w, 0);
        end

        wr(3'd0, 0, cfgw(1, 2'd0, 0, 0));
        wr(3'd0, 1, cfgw(0, 2'd0, 1, 0));
        wr(3'd0, 2, cfgw(0, 2'd1, 0, 0));
        wr(3'd2, 3, 32'h0055);
        wr(3'd0, 3, cfgw(0, 2'd2, 0, 0));
        // R2: selected software channel only; ch2 selected but timer-sourced
        wr(3'd3, 0, 32'b0101);
        wr(3'd4, 0, 32'h1);
        chk("R2 busy after start", busy_o, 4'b0001);
        chk("R2 req after start", req_o, 4'b0001);
        wr(3'd3, 0, 32'b0011);
        wr(3'd4, 0, 32'h1);
        chk("R2 busy second start", busy_o, 4'b0011);

        // R5/R7/R8: single-mode result on ch0, repeat result on ch1
        conv(0, 12'hABC);
        chk("R5 single clears busy", busy_o[0], 0);
        chk("R7 irq ch0", irq_o[0], 1);
        rd(0, w);
        chk("R8 read ch0", w, word(0, 0, 12'hABC));
        conv(1, 12'h123);
        chk("R5 repeat keeps req", req_o[1], 1);
        chk("R7 irq masked by enable", irq_o[1], 0);

        // R6
        wr(3'd1, 1, 32'h1);
        chk("R6 busy cleared", busy_o[1], 0);

        // R3
        @(negedge clk); tmr_trig = 4'b0101;
        @(negedge clk); tmr_trig = 4'b0000;
        chk("R3 timer channel", busy_o[2], 1);
        chk("R3 software channel ignores timer", busy_o[0], 0);

        // R4
        @(negedge clk); frc = 16'h0054;
        @(negedge clk);
        chk("R4 no match", busy_o[3], 0);
        frc = 16'h0055;
        @(negedge clk);
        chk("R4 match", busy_o[3], 1);
        frc = 16'hFFFF;

        // R7 clear
        wr(3'd1, 0, 32'h2);
        chk("R7 flag clear", irq_o[0], 0);

        // R9 overrun unprotected
        conv(0, 12'h111);
        conv(0, 12'h222);
        rd(0, w);
        chk("R9 overrun word", w, word(1, 1, 12'h222));
        rd(0, w);
        chk("R9 read clears ERR", w, word(0, 0, 12'h222));

        // R10 protection lock on ch1 (repeat, software)
        wr(3'd1, 1, 32'h2);
        wr(3'd0, 1, cfgw(1, 2'd0, 1, 1));
        wr(3'd3, 0, 32'b0010);
        wr(3'd4, 0, 32'h1);
        chk("R10 request before lock", req_o[1], 1);
        conv(1, 12'h345);
        chk("R10 locked no req", req_o[1], 0);
        chk("R10 locked still busy", busy_o[1], 1);
        wr(3'd4, 0, 32'h1);
        chk("R10 start ignored while locked", req_o[1], 0);
        conv(1, 12'h777);
        rd(1, w);
        chk("R10 locked overrun keeps old", w, word(1, 0, 12'h345));
        idle(2);
        chk("R10 read alone no release", req_o[1], 0);
        wr(3'd1, 1, 32'h2);
        idle(2);
        chk("R10 release resumes repeat", req_o[1], 1);

        // R11 compare channel ignores protection
        wr(3'd1, 3, 32'h1);
        wr(3'd0, 3, cfgw(1, 2'd2, 0, 1));
        @(negedge clk); frc = 16'h0055;
        @(negedge clk); frc = 16'hFFFF;
        chk("R11 match request", req_o[3], 1);
        conv(3, 12'h0AA);
        chk("R11 single done", busy_o[3], 0);
        @(negedge clk); frc = 16'h0055;
        @(negedge clk); frc = 16'hFFFF;
        chk("R11 reactivates with flag set", req_o[3], 1);

        // R9/R7 random stream on ch0
        wr(3'd1, 0, 32'h2);
        m_int = 0; m_err = 0; m_errst = 0; m_data = 12'h222;
        for (int k = 0; k < 60; k++) begin
            int op;
            op = $urandom_range(0, 2);
            if (op == 0) begin
                logic [11:0] d;
                d = 12'($urandom);
                conv(0, d);
                if (m_int) begin m_err = 1; m_errst = 1; end
                m_data = d; m_int = 1;
            end else if (op == 1) begin
                rd(0, w);
                chk("R9 random read", w, word(m_err, m_errst, m_data));
                m_err = 0; m_errst = 0;
            end else begin
                wr(3'd1, 0, 32'h2);
                m_int = 0;
            end
            chk("R7 random irq", irq_o[0], m_int);
        end

        finished = 1;
        summary();
    end

endmodule